// File: doc/BRIEF.md
# Index and Stack Register Group with Precharged Special Bus

This block holds the two index registers and the stack pointer of an 8-bit processor datapath. It exchanges values with the rest of the datapath over a shared special bus. That bus is precharged high in the second clock phase and pulled low by its drivers in the first. Per-cycle transfer strobes choose which registers put their value on the bus and which registers take the bus value. Every active driver, including any drive that already comes from outside the block, pulls bits low. The bus therefore settles to the bitwise AND of all the active drivers.

The stack pointer can also put its value on the low address bus. It has an explicit hold strobe that keeps its current value. One clock cycle of the model is one phase. The phase inputs say which phase the cycle belongs to. A register that is written takes the resolved bus value at the clock edge that ends a first-phase cycle. Stepping the stack pointer up or down, the ALU and instruction decoding belong to other blocks.

Top module: `idx_stack_regs`

## Requirements
- R1: While `rst_n` is low, the X, Y and stack-pointer registers are cleared to 0x00 without waiting for a clock edge.
- R2: In a cycle with `ph2` high, `sbus` reads 0xFF and no register loads. This holds even when `ph1` is also high, and it holds whatever the strobes and the external drive are.
- R3: In a cycle with `ph1` high and `ph2` low, `sbus` reads 0xFF when nothing drives it. It also reads 0xFF when neither phase input is high.
- R4: In a cycle with `ph1` high and `ph2` low, `sbus` equals the bitwise AND of every active driver. The drivers are Y (`y_drv`), X (`x_drv`), the stack pointer (`sp_drv`) and `ext_val` (`ext_drv`).
- R5: In a cycle with `ph1` high and `ph2` low, `x_ld` loads X and `y_ld` loads Y. Each takes the `sbus` value of that same cycle, and the new value appears after the rising clock edge.
- R6: In a cycle with `ph1` high and `ph2` low, `sp_ld` loads the stack pointer from the `sbus` value of that same cycle.
- R7: When `sp_ld` and `sp_hold` are both high in a first-phase cycle, the load is the one that takes effect.
- R8: The stack pointer keeps its value when `sp_hold` is high and `sp_ld` is low. It also keeps its value when both are low.
- R9: `adr_lo` equals the stack pointer when `ph1` is high, `ph2` is low and `sp_adr` is high. In every other cycle it reads 0xFF.
- R10: X and Y keep their values in any cycle in which their own load strobe is low, even when other registers load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1 | input | 1 | Cycle is a transfer (first) phase |
| ph2 | input | 1 | Cycle is a precharge (second) phase |
| y_drv | input | 1 | Y drives the special bus |
| y_ld | input | 1 | Y loads from the special bus |
| x_drv | input | 1 | X drives the special bus |
| x_ld | input | 1 | X loads from the special bus |
| sp_drv | input | 1 | Stack pointer drives the special bus |
| sp_adr | input | 1 | Stack pointer drives the low address bus |
| sp_ld | input | 1 | Stack pointer loads from the special bus |
| sp_hold | input | 1 | Stack pointer recirculates its value |
| ext_drv | input | 1 | Outside logic drives the special bus |
| ext_val | input | 8 | Value driven from outside |
| sbus | output | 8 | Resolved special-bus value |
| adr_lo | output | 8 | Stack pointer's share of the low address bus |
| x_val | output | 8 | Current X value |
| y_val | output | 8 | Current Y value |
| sp_val | output | 8 | Current stack-pointer value |

## Verification
A wrong register value shows up on `x_val`, `y_val` or `sp_val` in the cycle after the faulty load. It also corrupts `sbus` as soon as that register drives the bus in a later first phase, and then it spreads into any register loaded in that cycle. A fault in resolving the bus shows up at once on `sbus`, in the same cycle. A fault in the phase gating shows up as a register that changes during a precharge cycle. The vectors therefore chain transfers register to register, so that a bad value is carried forward and compared on every later step.

// File: rtl/isr_pkg.sv
package isr_pkg;
    // Default datapath word width for the register group
    parameter int unsigned WORD_W = 8;
    // Number of special-bus drivers: Y, X, stack pointer, external
    parameter int unsigned NUM_DRV = 4;
    localparam int unsigned DRV_Y   = 0;
    localparam int unsigned DRV_X   = 1;
    localparam int unsigned DRV_SP  = 2;
    localparam int unsigned DRV_EXT = 3;
endpackage

// File: rtl/sbus_wand.sv
// Wired-AND resolution of the precharged special bus.
module sbus_wand #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 4
) (
    input  logic                act,
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] val,
    output logic [W-1:0]        bus
);
    logic [N-1:0][W-1:0] masked;

    // An idle driver leaves the precharged ones untouched
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign masked[i] = en[i] ? val[i] : {W{1'b1}};
    end

    always_comb begin
        logic [W-1:0] acc_d;
        acc_d = {W{1'b1}};
        for (int i = 0; i < N; i++) begin
            acc_d = acc_d & masked[i];
        end
        bus = act ? acc_d : {W{1'b1}};
    end
endmodule

// File: rtl/bus_reg_cell.sv
// One bus-loaded register with an optional recirculate strobe.
module bus_reg_cell #(
    parameter int unsigned   W   = 8,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         hold,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.val = din;
        end else if (hold) begin
            st_d.val = st_q.val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{val: RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/adr_lo_gate.sv
// Stack pointer onto the precharged low address bus.
module adr_lo_gate #(
    parameter int unsigned W = 8
) (
    input  logic         act,
    input  logic         sel,
    input  logic [W-1:0] sp,
    output logic [W-1:0] adr
);
    always_comb begin
        adr = {W{1'b1}};
        if (act && sel) begin
            adr = sp;
        end
    end
endmodule

// File: rtl/idx_stack_regs.sv
module idx_stack_regs #(
    parameter int unsigned DATA_W = isr_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph1,
    input  logic              ph2,
    input  logic              y_drv,
    input  logic              y_ld,
    input  logic              x_drv,
    input  logic              x_ld,
    input  logic              sp_drv,
    input  logic              sp_adr,
    input  logic              sp_ld,
    input  logic              sp_hold,
    input  logic              ext_drv,
    input  logic [DATA_W-1:0] ext_val,
    output logic [DATA_W-1:0] sbus,
    output logic [DATA_W-1:0] adr_lo,
    output logic [DATA_W-1:0] x_val,
    output logic [DATA_W-1:0] y_val,
    output logic [DATA_W-1:0] sp_val
);
    import isr_pkg::*;

    localparam int unsigned ND = NUM_DRV;

    // Transfer phase: first phase without precharge (precharge wins)
    logic act;
    assign act = ph1 & ~ph2;

    logic [ND-1:0]             drv_en;
    logic [ND-1:0][DATA_W-1:0] drv_val;

    always_comb begin
        drv_en           = '0;
        drv_val          = '0;
        drv_en[DRV_Y]    = y_drv;
        drv_val[DRV_Y]   = y_val;
        drv_en[DRV_X]    = x_drv;
        drv_val[DRV_X]   = x_val;
        drv_en[DRV_SP]   = sp_drv;
        drv_val[DRV_SP]  = sp_val;
        drv_en[DRV_EXT]  = ext_drv;
        drv_val[DRV_EXT] = ext_val;
    end

    sbus_wand #(.W(DATA_W), .N(ND)) u_bus (
        .act (act),
        .en  (drv_en),
        .val (drv_val),
        .bus (sbus)
    );

    bus_reg_cell #(.W(DATA_W), .RST('0)) u_y (
        .clk (clk), .rst_n (rst_n), .ld (act & y_ld), .hold (1'b0),
        .din (sbus), .q (y_val)
    );

    bus_reg_cell #(.W(DATA_W), .RST('0)) u_x (
        .clk (clk), .rst_n (rst_n), .ld (act & x_ld), .hold (1'b0),
        .din (sbus), .q (x_val)
    );

    bus_reg_cell #(.W(DATA_W), .RST('0)) u_sp (
        .clk (clk), .rst_n (rst_n), .ld (act & sp_ld), .hold (act & sp_hold),
        .din (sbus), .q (sp_val)
    );

    adr_lo_gate #(.W(DATA_W)) u_adr (
        .act (act),
        .sel (sp_adr),
        .sp  (sp_val),
        .adr (adr_lo)
    );
endmodule

// File: rtl/isr_checker.sv
module isr_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ph1,
    input logic              ph2,
    input logic              y_drv,
    input logic              y_ld,
    input logic              x_drv,
    input logic              x_ld,
    input logic              sp_drv,
    input logic              sp_adr,
    input logic              sp_ld,
    input logic              sp_hold,
    input logic              ext_drv,
    input logic [DATA_W-1:0] ext_val,
    input logic [DATA_W-1:0] sbus,
    input logic [DATA_W-1:0] adr_lo,
    input logic [DATA_W-1:0] x_val,
    input logic [DATA_W-1:0] y_val,
    input logic [DATA_W-1:0] sp_val
);
    logic xfer;
    assign xfer = ph1 && !ph2;

    p_precharge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph2 |-> (sbus == {DATA_W{1'b1}}));

    p_wand_y_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && y_drv) |-> ((sbus & ~y_val) == '0));

    p_wand_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && ext_drv) |-> ((sbus & ~ext_val) == '0));

    p_x_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && x_ld) |=> (x_val == $past(sbus)));

    p_sp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && sp_ld) |=> (sp_val == $past(sbus)));

    p_sp_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer && sp_ld) |=> $stable(sp_val));

    p_y_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer && y_ld) |=> $stable(y_val));

    p_adr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer && sp_adr) |-> (adr_lo == {DATA_W{1'b1}}));

    p_adr_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && sp_adr) |-> (adr_lo == sp_val));
endmodule

bind idx_stack_regs isr_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_idx_stack_regs.sv
`timescale 1ns/1ps
module sim_idx_stack_regs;
    logic clk = 1'b0;
    logic rst_n, ph1, ph2;
    logic y_drv, y_ld, x_drv, x_ld, sp_drv, sp_adr, sp_ld, sp_hold, ext_drv;
    logic [7:0] ext_val, sbus, adr_lo, x_val, y_val, sp_val;

    always #2.5 clk = ~clk;

    idx_stack_regs u0 (.*);

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // strobe bits: 7 y_drv, 6 y_ld, 5 x_drv, 4 x_ld, 3 sp_drv, 2 sp_adr, 1 sp_ld, 0 sp_hold
    typedef struct packed {
        logic       p1;
        logic       p2;
        logic [7:0] stb;
        logic       ee;
        logic [7:0] ev;
        logic [7:0] e_bus;
        logic [7:0] e_adr;
        logic [7:0] e_x;
        logic [7:0] e_y;
        logic [7:0] e_sp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1,0,8'h10,1,8'hA5, 8'hA5,8'hFF, 8'hA5,8'h00,8'h00}, // R5 ext->X
        '{1,0,8'h40,1,8'h3C, 8'h3C,8'hFF, 8'hA5,8'h3C,8'h00}, // R5 ext->Y, R10 X kept
        '{1,0,8'h02,1,8'hF0, 8'hF0,8'hFF, 8'hA5,8'h3C,8'hF0}, // R6 ext->SP
        '{1,0,8'h60,0,8'h00, 8'hA5,8'hFF, 8'hA5,8'hA5,8'hF0}, // R4 R5 X->Y
        '{1,0,8'h98,1,8'h7E, 8'h20,8'hFF, 8'h20,8'hA5,8'hF0}, // R4 AND of Y,SP,ext ->X
        '{1,0,8'h05,0,8'h00, 8'hFF,8'hF0, 8'h20,8'hA5,8'hF0}, // R3 R8 R9 hold+addr
        '{0,1,8'hFF,1,8'h00, 8'hFF,8'hFF, 8'h20,8'hA5,8'hF0}, // R2 precharge
        '{1,1,8'h5E,1,8'h11, 8'hFF,8'hFF, 8'h20,8'hA5,8'hF0}, // R2 both phases
        '{1,0,8'h03,1,8'h5A, 8'h5A,8'hFF, 8'h20,8'hA5,8'h5A}, // R7 load beats hold
        '{1,0,8'h00,0,8'h00, 8'hFF,8'hFF, 8'h20,8'hA5,8'h5A}, // R3 R8 idle
        '{1,0,8'h0E,1,8'h0F, 8'h0A,8'h5A, 8'h20,8'hA5,8'h0A}, // R4 R6 R9
        '{1,0,8'h30,0,8'h00, 8'h20,8'hFF, 8'h20,8'hA5,8'h0A}, // R5 X self
        '{0,0,8'h56,1,8'h00, 8'hFF,8'hFF, 8'h20,8'hA5,8'h0A}  // R3 no phase
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        ph1 = v.p1; ph2 = v.p2;
        {y_drv, y_ld, x_drv, x_ld, sp_drv, sp_adr, sp_ld, sp_hold} = v.stb;
        ext_drv = v.ee; ext_val = v.ev;
    endtask

    initial begin
        rst_n = 1'b0; ph1 = 0; ph2 = 0;
        {y_drv, y_ld, x_drv, x_ld, sp_drv, sp_adr, sp_ld, sp_hold} = '0;
        ext_drv = 0; ext_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 x reset", x_val, 8'h00);
        chk("R1 y reset", y_val, 8'h00);
        chk("R1 sp reset", sp_val, 8'h00);
        chk("R3 idle bus", sbus, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            chk("R4 sbus", sbus, VECS[i].e_bus);
            chk("R9 adr_lo", adr_lo, VECS[i].e_adr);
            @(posedge clk);
            #1;
            chk("R5 x", x_val, VECS[i].e_x);
            chk("R10 y", y_val, VECS[i].e_y);
            chk("R6 sp", sp_val, VECS[i].e_sp);
        end

        // R1: asynchronous clear in the middle of a run
        @(negedge clk);
        apply('0);
        rst_n = 1'b0;
        #1;
        chk("R1 async x", x_val, 8'h00);
        chk("R1 async y", y_val, 8'h00);
        chk("R1 async sp", sp_val, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: hold alone across several cycles after a load
        @(negedge clk);
        ph1 = 1; sp_ld = 1; ext_drv = 1; ext_val = 8'hC3;
        @(posedge clk); #1;
        chk("R6 sp reload", sp_val, 8'hC3);
        @(negedge clk);
        sp_ld = 0; sp_hold = 1; ext_val = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 sp hold", sp_val, 8'hC3);
        chk("R10 x untouched", x_val, 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule